// File: doc/BRIEF.md
# Pipelined Byte-Write SRAM Datapath

This block is the data side of a synchronous pipelined static memory. Its word is 64 bits, split into eight byte lanes, and its depth is a parameter. An external burst sequencer supplies the word address each cycle, together with a flag that says whether an access is wanted. The sequencer also says whether this access is a start raised by the processor-side address strobe. The block decodes a global write control, a lane-write enable and eight lane selects into per-lane write strobes. Address, controls and write data are captured on one rising edge, and the array write happens on the next one.

Read data passes through an output register, so a read captured on edge k appears after edge k+1. The output enable acts without a clock and gates whether the read data is driven. When the outputs are not driven they read as zero. A sleep input removes the outputs at once and blocks new accesses. After two consecutive sampled edges it enters a power-down state in which the stored data is kept. When the block leaves that state, a two-cycle recovery window follows in which every access request is dropped.

Top module: `sync_bytewrite_sram`

## Requirements
- R1: On an accepted access that is not a processor start, a low `all_wr_n_i` writes all eight lanes of `wdata_i` at `addr_i`, whatever `lane_wr_en_n_i` and `lane_sel_n_i` hold.
- R2: With `all_wr_n_i` high and `lane_wr_en_n_i` low, lane n (bit n of `lane_sel_n_i`, n = 0..7) writes data bits 8n+7..8n when that bit is low. Lanes whose bit is high keep their old contents.
- R3: With `all_wr_n_i` and `lane_wr_en_n_i` both high, an accepted access is a read, whatever the lane selects hold. No lane changes, and the word is returned on `rdata_o`.
- R4: An accepted access with `cpu_start_i` high is always a read. The write controls have no effect in that cycle, and the memory is left unchanged.
- R5: A read accepted on edge k shows its word on `rdata_o`, with `drive_o` high, after edge k+1. Back-to-back reads stream one word per cycle.
- R6: `drive_o` is high only when the access captured on the previous edge was a read, `out_en_n_i` is low and `sleep_i` is low. After a write, `drive_o` is low. While `drive_o` is low, `rdata_o` is zero.
- R7: `out_en_n_i` and `sleep_i` change `drive_o` and `rdata_o` without waiting for a clock edge.
- R8: A cycle with `access_i` low performs no access: memory is unchanged and `drive_o` is low after the next edge.
- R9: Any edge that samples `sleep_i` high accepts no access. `sleep_o` rises after `sleep_i` has been high at two consecutive edges, and a one-edge pulse does not enter sleep. Stored contents survive sleep.
- R10: On the edge that leaves sleep (`sleep_i` low while `sleep_o` is high), `recov_busy_o` rises and stays high for two cycles. Accesses on those two edges are ignored, and the first access after the window is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_i | input | 1 | Sequencer requests an access this cycle |
| cpu_start_i | input | 1 | Access is a processor-strobe start (forced read) |
| addr_i | input | AW | Word address from the sequencer |
| all_wr_n_i | input | 1 | Global write, active low |
| lane_wr_en_n_i | input | 1 | Enables lane selects, active low |
| lane_sel_n_i | input | LANES | Per-lane write selects, active low |
| wdata_i | input | DATA_W | Write data |
| out_en_n_i | input | 1 | Output enable, active low, unclocked |
| sleep_i | input | 1 | Power-down request |
| rdata_o | output | DATA_W | Read data, zero when not driven |
| drive_o | output | 1 | Read data is being driven |
| sleep_o | output | 1 | Power-down state entered |
| recov_busy_o | output | 1 | Wake-up recovery window active |

## Verification
The checker watches every cycle for the following behaviours:
- how an accepted access is classified (global write, forced read on a processor start, read when both write controls are high);
- that an idle cycle leaves the stage empty;
- that a captured read makes the output register valid one edge later;
- that `drive_o` is never high without the enable, with sleep high or without valid data;
- that sleep and recovery never let an access through, and that leaving sleep always opens the busy window.

Only the bench scenarios can show the data itself: the lane-by-lane merge over all 256 select patterns, the exact word and cycle of streamed reads, contents kept across sleep, and the unclocked response to the output enable.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Classify one cycle from its controls; a processor start is never a write.
  function automatic op_e classify(input logic go,
                                   input logic cpu_start,
                                   input logic all_wr_n,
                                   input logic lane_wr_en_n,
                                   input logic any_lane_low);
    if (!go)
      return OP_NONE;
    if (cpu_start)
      return OP_READ;
    if (!all_wr_n || (!lane_wr_en_n && any_lane_low))
      return OP_WRITE;
    return OP_READ;
  endfunction

endpackage

// File: rtl/sbp_wdec.sv
module sbp_wdec #(
  parameter int unsigned LANES = 8
) (
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] strb,
  output logic             any_lane_low
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strb[g] = ~all_wr_n | (~lane_wr_en_n & ~lane_sel_n[g]);
  end

  assign any_lane_low = ~&lane_sel_n;
endmodule

// File: rtl/sbp_sleep.sv
module sbp_sleep #(
  parameter int unsigned RECOV_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  output logic seen_o,
  output logic asleep_o,
  output logic busy_o,
  output logic block_o
);
  localparam int unsigned CW = $clog2(RECOV_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_o   <= 1'b0;
      asleep_o <= 1'b0;
      cnt_q    <= '0;
    end else begin
      seen_o   <= sleep_i;
      asleep_o <= sleep_i & (seen_o | asleep_o);
      if (asleep_o && !sleep_i)
        cnt_q <= CW'(RECOV_CYC);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign block_o = sleep_i | asleep_o | busy_o;
endmodule

// File: rtl/sbp_stage.sv
module sbp_stage
  import sbp_pkg::*;
#(
  parameter int unsigned AW     = 4,
  parameter int unsigned LANES  = 8,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_d,
  input  logic [AW-1:0]     addr_d,
  input  logic [LANES-1:0]  strb_d,
  input  logic [DATA_W-1:0] wdata_d,
  output op_e               op_q,
  output logic [AW-1:0]     addr_q,
  output logic [LANES-1:0]  strb_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      addr_q  <= '0;
      strb_q  <= '0;
      wdata_q <= '0;
    end else begin
      op_q <= op_d;
      if (op_d != OP_NONE) begin
        addr_q  <= addr_d;
        strb_q  <= strb_d;
        wdata_q <= wdata_d;
      end
    end
  end
endmodule

// File: rtl/sbp_array.sv
module sbp_array #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned AW     = 4,
  parameter int unsigned LANES  = 8,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  strb,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned LW = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && strb[g])
        mem[addr] <= wdata[g*LW +: LW];
    end

    assign rdata[g*LW +: LW] = mem[addr];
  end
endmodule

// File: rtl/sbp_outreg.sv
module sbp_outreg #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= load;
      if (load)
        dout <= din;
    end
  end
endmodule

// File: rtl/sync_bytewrite_sram.sv
module sync_bytewrite_sram
  import sbp_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned LANES     = 8,
  parameter int unsigned RECOV_CYC = 2,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_i,
  input  logic              cpu_start_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              all_wr_n_i,
  input  logic              lane_wr_en_n_i,
  input  logic [LANES-1:0]  lane_sel_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              out_en_n_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o,
  output logic              sleep_o,
  output logic              recov_busy_o
);
  // named internal events, observed by the bound checker
  logic              sleep_seen;
  logic              blocked;
  logic              accept_w;
  logic              any_lane_low;
  logic [LANES-1:0]  strb_d;
  op_e               op_d;
  op_e               op_q;
  logic [AW-1:0]     addr_q;
  logic [LANES-1:0]  strb_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] out_q;
  logic              out_vld;

  sbp_sleep #(.RECOV_CYC(RECOV_CYC)) u_sleep (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_i  (sleep_i),
    .seen_o   (sleep_seen),
    .asleep_o (sleep_o),
    .busy_o   (recov_busy_o),
    .block_o  (blocked)
  );

  sbp_wdec #(.LANES(LANES)) u_wdec (
    .all_wr_n     (all_wr_n_i),
    .lane_wr_en_n (lane_wr_en_n_i),
    .lane_sel_n   (lane_sel_n_i),
    .strb         (strb_d),
    .any_lane_low (any_lane_low)
  );

  assign accept_w = access_i & ~blocked;
  assign op_d     = classify(accept_w, cpu_start_i, all_wr_n_i,
                             lane_wr_en_n_i, any_lane_low);

  sbp_stage #(.AW(AW), .LANES(LANES), .DATA_W(DATA_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_d    (op_d),
    .addr_d  (addr_i),
    .strb_d  (strb_d),
    .wdata_d (wdata_i),
    .op_q    (op_q),
    .addr_q  (addr_q),
    .strb_q  (strb_q),
    .wdata_q (wdata_q)
  );

  assign wr_fire = (op_q == OP_WRITE);
  assign rd_fire = (op_q == OP_READ);

  sbp_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (wr_fire),
    .strb  (strb_q),
    .addr  (addr_q),
    .wdata (wdata_q),
    .rdata (arr_rdata)
  );

  sbp_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_fire),
    .din   (arr_rdata),
    .dout  (out_q),
    .vld   (out_vld)
  );

  assign drive_o = out_vld & ~out_en_n_i & ~sleep_i;
  assign rdata_o = drive_o ? out_q : '0;
endmodule

// File: rtl/sbp_chk.sv
module sbp_chk #(
  parameter int unsigned LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             access_i,
  input logic             cpu_start_i,
  input logic             all_wr_n_i,
  input logic             lane_wr_en_n_i,
  input logic             out_en_n_i,
  input logic             sleep_i,
  input logic             sleep_o,
  input logic             recov_busy_o,
  input logic             sleep_seen,
  input logic             accept_w,
  input logic             wr_fire,
  input logic             rd_fire,
  input logic [LANES-1:0] strb_q,
  input logic             out_vld,
  input logic             drive_o
);
  // R1
  global_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !cpu_start_i && !all_wr_n_i) |=> (wr_fire && strb_q == {LANES{1'b1}}));

  // R3
  plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !cpu_start_i && all_wr_n_i && lane_wr_en_n_i) |=> rd_fire);

  // R4
  cpu_start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && cpu_start_i) |=> (rd_fire && !wr_fire));

  // R5
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> out_vld);

  // R6
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> (!out_en_n_i && !sleep_i && out_vld));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !access_i |=> !(rd_fire || wr_fire));

  // R9
  sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && sleep_seen) |=> sleep_o);

  // R9
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i || sleep_o) |-> !accept_w);

  // R10
  wake_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> recov_busy_o);

  // R10
  recov_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_busy_o |-> !accept_w);
endmodule

bind sync_bytewrite_sram sbp_chk #(.LANES(LANES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .access_i       (access_i),
  .cpu_start_i    (cpu_start_i),
  .all_wr_n_i     (all_wr_n_i),
  .lane_wr_en_n_i (lane_wr_en_n_i),
  .out_en_n_i     (out_en_n_i),
  .sleep_i        (sleep_i),
  .sleep_o        (sleep_o),
  .recov_busy_o   (recov_busy_o),
  .sleep_seen     (sleep_seen),
  .accept_w       (accept_w),
  .wr_fire        (wr_fire),
  .rd_fire        (rd_fire),
  .strb_q         (strb_q),
  .out_vld        (out_vld),
  .drive_o        (drive_o)
);

// File: tb/test_sync_bytewrite_sram.sv
`timescale 1ns/1ps
module test_sync_bytewrite_sram;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        access_i = 1'b0;
  logic        cpu_start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic        all_wr_n_i = 1'b1;
  logic        lane_wr_en_n_i = 1'b1;
  logic [7:0]  lane_sel_n_i = 8'hFF;
  logic [63:0] wdata_i = '0;
  logic        out_en_n_i = 1'b0;
  logic        sleep_i = 1'b0;
  logic [63:0] rdata_o;
  logic        drive_o, sleep_o, recov_busy_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [63:0] model [DEPTH];

  always #2 clk = ~clk;

  sync_bytewrite_sram #(.DEPTH(DEPTH)) i_sync_bytewrite_sram (
    .clk(clk), .rst_n(rst_n), .access_i(access_i), .cpu_start_i(cpu_start_i),
    .addr_i(addr_i), .all_wr_n_i(all_wr_n_i), .lane_wr_en_n_i(lane_wr_en_n_i),
    .lane_sel_n_i(lane_sel_n_i), .wdata_i(wdata_i), .out_en_n_i(out_en_n_i),
    .sleep_i(sleep_i), .rdata_o(rdata_o), .drive_o(drive_o), .sleep_o(sleep_o),
    .recov_busy_o(recov_busy_o)
  );

  function automatic logic [63:0] pat(int s);
    return (64'(s) * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0F1E_2D3C_4B5A_6978;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    access_i = 0; cpu_start_i = 0; all_wr_n_i = 1; lane_wr_en_n_i = 1;
    lane_sel_n_i = 8'hFF;
  endtask

  task automatic put(logic acc, logic cpu, int a, logic gw_n, logic lw_n,
                     logic [7:0] sel_n, logic [63:0] d);
    access_i = acc; cpu_start_i = cpu; addr_i = AW'(a); all_wr_n_i = gw_n;
    lane_wr_en_n_i = lw_n; lane_sel_n_i = sel_n; wdata_i = d;
    tick();
    idle();
  endtask

  task automatic rd_chk(string tag, int a);
    put(1, 0, a, 1, 1, 8'hFF, '0);
    tick();
    chk({tag, " drive"}, 64'(drive_o), 64'd1);
    chk(tag, rdata_o, model[a]);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset drive_o", 64'(drive_o), 0);
    chk("reset rdata_o", rdata_o, 0);
    chk("reset busy/sleep", 64'({recov_busy_o, sleep_o}), 0);
    rst_n = 1;
    tick();

    // R1: global write fills every lane, lane controls ignored
    for (int a = 0; a < DEPTH; a++) begin
      put(1, 0, a, 0, a[0], 8'(a * 37), pat(a));
      model[a] = pat(a);
    end
    for (int a = 0; a < DEPTH; a++) rd_chk("R1 global write", a);

    // R2: all 256 lane-select patterns, merged in the bench model
    for (int s = 0; s < 256; s++) begin
      int a = s % DEPTH;
      logic [63:0] d = pat(s + 1000);
      put(1, 0, a, 1, 0, 8'(s), d);
      for (int l = 0; l < 8; l++)
        if (!s[l]) model[a][8*l +: 8] = d[8*l +: 8];
      rd_chk("R2 lane merge", a);
    end

    // R3: both write controls high -> read, lane selects ignored
    put(1, 0, 3, 1, 1, 8'h00, ~model[3]);
    tick();
    chk("R3 read returned", rdata_o, model[3]);
    rd_chk("R3 unchanged", 3);

    // R4: processor start with write controls asserted is a read
    put(1, 1, 5, 0, 0, 8'h00, ~model[5]);
    tick();
    chk("R4 read returned", rdata_o, model[5]);
    rd_chk("R4 unchanged", 5);

    // R5: streamed reads, one word per cycle, one cycle behind
    for (int i = 0; i < DEPTH; i++) begin
      access_i = 1; addr_i = AW'(i);
      tick();
      if (i > 0) chk("R5 stream", rdata_o, model[i-1]);
    end
    idle();
    tick();
    chk("R5 stream last", rdata_o, model[DEPTH-1]);

    // R7: unclocked output enable
    out_en_n_i = 1; #0.5;
    chk("R7 oe off drive", 64'(drive_o), 0);
    chk("R7 oe off data", rdata_o, 0);
    out_en_n_i = 0; #0.5;
    chk("R7 oe on data", rdata_o, model[DEPTH-1]);

    // R6: after a write the outputs are not driven
    put(1, 0, 7, 0, 1, 8'hFF, pat(77));
    model[7] = pat(77);
    chk("R6 write drive_o", 64'(drive_o), 0);
    tick();
    chk("R6 write rdata_o", rdata_o, 0);
    rd_chk("R6 readback", 7);

    // R8: deselected cycle with write controls does nothing
    put(0, 0, 9, 0, 0, 8'h00, ~model[9]);
    chk("R8 idle drive_o", 64'(drive_o), 0);
    rd_chk("R8 unchanged", 9);

    // R9: one-edge sleep pulse does not enter sleep, blocks its access
    sleep_i = 1; access_i = 1; addr_i = 4'd2; all_wr_n_i = 0; wdata_i = ~model[2];
    tick();
    sleep_i = 0; idle();
    chk("R9 pulse sleep_o", 64'(sleep_o), 0);
    tick();
    chk("R9 pulse busy", 64'(recov_busy_o), 0);
    rd_chk("R9 pulse blocked", 2);

    // R9: sleep entry, async output removal, retention
    #0.1;
    sleep_i = 1; #0.5;
    chk("R9 sleep drive async", 64'(drive_o), 0);
    access_i = 1; addr_i = 4'd3; all_wr_n_i = 0; wdata_i = ~model[3];
    tick();
    chk("R9 sleep_o after 1", 64'(sleep_o), 0);
    tick();
    chk("R9 sleep_o after 2", 64'(sleep_o), 1);
    repeat (3) tick();
    // R10: leave sleep while writes are attempted
    sleep_i = 0; addr_i = 4'd4; wdata_i = ~model[4];
    tick();
    chk("R10 busy after release", 64'({recov_busy_o, sleep_o}), 64'b10);
    addr_i = 4'd5; wdata_i = ~model[5];
    tick();
    chk("R10 busy second", 64'(recov_busy_o), 1);
    addr_i = 4'd6; wdata_i = ~model[6];
    tick();
    chk("R10 busy ended", 64'(recov_busy_o), 0);
    idle();
    rd_chk("R9 retained", 3);
    rd_chk("R10 blocked a", 4);
    rd_chk("R10 blocked b", 5);
    rd_chk("R10 blocked c", 6);
    put(1, 0, 8, 0, 1, 8'hFF, pat(88));
    model[8] = pat(88);
    rd_chk("R10 accepted after window", 8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule